// File: doc/BRIEF.md
# Blocked-Access Interrupt Capture

This block sits beside a memory protection gate and keeps a record of the first transfer that the gate refuses. Each refusal arrives as a single-cycle event carrying the transfer address, the 16-bit identity of the requester, the transfer's non-secure attribute and the security bit that the lookup table held for the targeted block. The first event seen while the status flag is low latches these values into two information words and raises the status flag. Later refusals are still reported by the gate, but leave the record alone until software clears the flag. This way the record always describes the transfer that started the episode.

The interrupt line is a level: it is high whenever the status flag and the enable flag are both set. A register bank in front of the block decodes bus addresses. It hands this block one-cycle write strobes for the set, clear and enable registers, and the least significant bit of the write data. It also passes a read select code, and the block returns the matching 32-bit read value. Software can force the status flag high through the set register, which is useful for testing the interrupt path.

Top module: `blkcap_top`

## Requirements
- R1: `irq` is high exactly when the status flag and the enable flag are both 1, and it follows them in the same cycle.
- R2: A block event (`blk_evt`=1) sampled while status is 0 sets status at that clock edge and loads the event's address into info1, zero-extended to 32 bits.
- R3: On capture, info2 holds the requester ID in bits 15:0, the non-secure attribute in bit 16, the lookup security bit in bit 17, and zeros in bits 31:18.
- R4: A block event sampled while status is 1, with no effective clear write in the same cycle, leaves status, info1 and info2 unchanged.
- R5: A clear write (`wr_clr`=1) with `wr_lsb`=1 clears status and keeps info1 and info2. With `wr_lsb`=0 it has no effect.
- R6: A set write (`wr_set`=1) with `wr_lsb`=1 sets status without touching info1 or info2. With `wr_lsb`=0 it has no effect.
- R7: When an effective set write and an effective clear write fall in the same cycle, status ends at 1.
- R8: When a block event and an effective clear write fall in the same cycle, status ends at 1 and the event's information is captured, even if status was already 1.
- R9: An enable write (`wr_en`=1) stores `wr_lsb` as the enable flag. Reads of the enable register return that flag in bit 0 and zeros above it.
- R10: Synchronous reset (`rst_n`=0 at a clock edge) sets enable to 1 and clears status, info1 and info2.
- R11: `rd_data` is selected by `rd_sel`: 0 gives status in bit 0, 1 gives enable in bit 0, 2 gives info1, 3 gives info2. Codes 4 (set) and 5 (clear) and any other code return zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| blk_evt | input | 1 | One-cycle pulse: the gate refused a transfer |
| blk_addr | input | ADDR_W | Address of the refused transfer |
| blk_req_id | input | REQ_W | Requester identity of the refused transfer |
| blk_nonsec | input | 1 | Non-secure attribute of the refused transfer |
| blk_lut_ns | input | 1 | Lookup security bit of the targeted block |
| wr_set | input | 1 | Write strobe for the set register |
| wr_clr | input | 1 | Write strobe for the clear register |
| wr_en | input | 1 | Write strobe for the enable register |
| wr_lsb | input | 1 | Bit 0 of the write data |
| rd_sel | input | 3 | Read select code |
| rd_data | output | DATA_W | Read value for the selected register |
| irq | output | 1 | Level interrupt |

## Verification
A wrong status flag shows on `irq` in the cycle right after the edge that corrupted it, as long as enable is set. The bench therefore checks `irq` and the status read after every stimulus edge. A capture at the wrong time shows as changed info words on the next read. This is why each repeated event, clear and set is followed at once by reads of both info words. An enable flag that is corrupted or has wide bits shows in the enable read and in an `irq` that no longer follows status.

// File: rtl/blkcap_pkg.sv
// Package: shared read-select codes and field widths for the
// blocked-access capture block. Assumes a 3-bit read select.
package blkcap_pkg;

    typedef enum logic [2:0] {
        SEL_STAT  = 3'd0,
        SEL_EN    = 3'd1,
        SEL_INFO1 = 3'd2,
        SEL_INFO2 = 3'd3,
        SEL_SET   = 3'd4,
        SEL_CLR   = 3'd5
    } rd_sel_e;

    localparam int unsigned SEL_W = 3;

endpackage

// File: rtl/blkcap_status.sv
// Module: status and enable flags with the interrupt level.
// Decides whether a block event captures. Assumes the write strobes
// are already qualified with bit 0 of the write data.
module blkcap_status (
    input  logic clk,
    input  logic rst_n,
    input  logic evt,
    input  logic set_hit,
    input  logic clr_hit,
    input  logic en_wr,
    input  logic en_val,
    output logic stat,
    output logic en,
    output logic capture,
    output logic irq
);

    logic stat_d;

    // Next status: an event wins over a clear, and a set wins over a clear.
    always_comb begin
        if (evt || set_hit) begin
            stat_d = 1'b1;
        end else if (clr_hit) begin
            stat_d = 1'b0;
        end else begin
            stat_d = stat;
        end
    end

    // Capture if status is low, or is being cleared in the same cycle.
    assign capture = evt && (!stat || clr_hit);

    // Status flag register.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            stat <= 1'b0;
        end else begin
            stat <= stat_d;
        end
    end

    // Enable flag register, reset to enabled.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            en <= 1'b1;
        end else if (en_wr) begin
            en <= en_val;
        end
    end

    // Level interrupt output.
    assign irq = stat & en;

endmodule

// File: rtl/blkcap_info.sv
// Module: the two info words latched on capture.
// Assumes ADDR_W <= DATA_W and REQ_W + 2 <= DATA_W.
module blkcap_info #(
    parameter int unsigned ADDR_W = 32,
    parameter int unsigned REQ_W  = 16,
    parameter int unsigned DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              capture,
    input  logic [ADDR_W-1:0] addr,
    input  logic [REQ_W-1:0]  req_id,
    input  logic              nonsec,
    input  logic              lut_ns,
    output logic [DATA_W-1:0] info1,
    output logic [DATA_W-1:0] info2
);

    localparam int unsigned NS_POS  = REQ_W;
    localparam int unsigned LUT_POS = REQ_W + 1;
    localparam int unsigned PAD_W   = DATA_W - REQ_W - 2;

    logic [DATA_W-1:0] addr_ext;
    logic [DATA_W-1:0] info2_d;

    // Zero-extend the address; the generate picks the variant.
    generate
        if (ADDR_W < DATA_W) begin : g_pad
            assign addr_ext = {{(DATA_W-ADDR_W){1'b0}}, addr};
        end else begin : g_full
            assign addr_ext = addr;
        end
    endgenerate

    // Pack the second info word.
    generate
        if (PAD_W > 0) begin : g_info2_pad
            assign info2_d[DATA_W-1:LUT_POS+1] = '0;
        end
    endgenerate
    assign info2_d[LUT_POS]     = lut_ns;
    assign info2_d[NS_POS]      = nonsec;
    assign info2_d[REQ_W-1:0]   = req_id;

    // Info registers: load only on capture.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            info1 <= '0;
            info2 <= '0;
        end else if (capture) begin
            info1 <= addr_ext;
            info2 <= info2_d;
        end
    end

endmodule

// File: rtl/blkcap_rdmux.sv
// Module: read multiplexer for the register bank. Write-only and unused
// codes read as zero.
module blkcap_rdmux #(
    parameter int unsigned DATA_W = 32
) (
    input  logic [blkcap_pkg::SEL_W-1:0] sel,
    input  logic                         stat,
    input  logic                         en,
    input  logic [DATA_W-1:0]            info1,
    input  logic [DATA_W-1:0]            info2,
    output logic [DATA_W-1:0]            data
);

    import blkcap_pkg::*;

    // Select the read value by code.
    always_comb begin
        data = '0;
        case (sel)
            SEL_STAT:  data[0] = stat;
            SEL_EN:    data[0] = en;
            SEL_INFO1: data = info1;
            SEL_INFO2: data = info2;
            default:   data = '0;
        endcase
    end

endmodule

// File: rtl/blkcap_top.sv
// Module: blocked-access interrupt capture top. Records the first refused
// transfer and drives a level interrupt. Assumes a register bank supplies
// decoded one-cycle write strobes and a read select code.
module blkcap_top #(
    parameter int unsigned ADDR_W = 32,
    parameter int unsigned REQ_W  = 16,
    parameter int unsigned DATA_W = 32
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         blk_evt,
    input  logic [ADDR_W-1:0]            blk_addr,
    input  logic [REQ_W-1:0]             blk_req_id,
    input  logic                         blk_nonsec,
    input  logic                         blk_lut_ns,
    input  logic                         wr_set,
    input  logic                         wr_clr,
    input  logic                         wr_en,
    input  logic                         wr_lsb,
    input  logic [blkcap_pkg::SEL_W-1:0] rd_sel,
    output logic [DATA_W-1:0]            rd_data,
    output logic                         irq
);

    logic set_hit;
    logic clr_hit;
    logic capture;
    logic stat_q;
    logic en_q;
    logic [DATA_W-1:0] info1_q;
    logic [DATA_W-1:0] info2_q;

    // Qualify set and clear strobes with the data bit.
    assign set_hit = wr_set & wr_lsb;
    assign clr_hit = wr_clr & wr_lsb;

    blkcap_status u_status (
        .clk     (clk),
        .rst_n   (rst_n),
        .evt     (blk_evt),
        .set_hit (set_hit),
        .clr_hit (clr_hit),
        .en_wr   (wr_en),
        .en_val  (wr_lsb),
        .stat    (stat_q),
        .en      (en_q),
        .capture (capture),
        .irq     (irq)
    );

    blkcap_info #(
        .ADDR_W (ADDR_W),
        .REQ_W  (REQ_W),
        .DATA_W (DATA_W)
    ) u_info (
        .clk     (clk),
        .rst_n   (rst_n),
        .capture (capture),
        .addr    (blk_addr),
        .req_id  (blk_req_id),
        .nonsec  (blk_nonsec),
        .lut_ns  (blk_lut_ns),
        .info1   (info1_q),
        .info2   (info2_q)
    );

    blkcap_rdmux #(
        .DATA_W (DATA_W)
    ) u_rdmux (
        .sel   (rd_sel),
        .stat  (stat_q),
        .en    (en_q),
        .info1 (info1_q),
        .info2 (info2_q),
        .data  (rd_data)
    );

endmodule

// File: rtl/blkcap_chk.sv
// Module: property checker for blkcap_top, attached by bind below.
module blkcap_chk #(
    parameter int unsigned REQ_W  = 16,
    parameter int unsigned DATA_W = 32
) (
    input logic              clk,
    input logic              rst_n,
    input logic              evt,
    input logic              set_hit,
    input logic              clr_hit,
    input logic              irq,
    input logic              stat,
    input logic              en,
    input logic [DATA_W-1:0] info1,
    input logic [DATA_W-1:0] info2
);

    // R1: interrupt never high without both flags
    a_r1_irq_needs_flags: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> (stat && en));

    // R1: both flags set gives interrupt
    a_r1_irq_when_flags: assert property (@(posedge clk) disable iff (!rst_n)
        (stat && en) |-> irq);

    // R2: event with status low raises status
    a_r2_capture_sets: assert property (@(posedge clk) disable iff (!rst_n)
        (evt && !stat) |=> stat);

    // R3: upper bits of info2 stay zero
    a_r3_info2_upper_zero: assert property (@(posedge clk) disable iff (!rst_n)
        info2[DATA_W-1:REQ_W+2] == '0);

    // R4: repeated event keeps the record
    a_r4_hold_record: assert property (@(posedge clk) disable iff (!rst_n)
        (evt && stat && !clr_hit) |=> (stat && $stable(info1) && $stable(info2)));

    // R5: clear alone drops status and keeps info
    a_r5_clear: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_hit && !set_hit && !evt) |=> (!stat && $stable(info1)));

    // R6: set raises status
    a_r6_set: assert property (@(posedge clk) disable iff (!rst_n)
        (set_hit && !evt) |=> (stat && $stable(info1) && $stable(info2)));

    // R8: event beats a concurrent clear
    a_r8_evt_beats_clear: assert property (@(posedge clk) disable iff (!rst_n)
        (evt && clr_hit) |=> stat);

endmodule

bind blkcap_top blkcap_chk #(
    .REQ_W  (REQ_W),
    .DATA_W (DATA_W)
) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .evt     (blk_evt),
    .set_hit (set_hit),
    .clr_hit (clr_hit),
    .irq     (irq),
    .stat    (stat_q),
    .en      (en_q),
    .info1   (info1_q),
    .info2   (info2_q)
);

// File: tb/blkcap_top_tb_top.sv
// Directed bench for blkcap_top: one task per scenario, 50 MHz clock.
module blkcap_top_tb_top;

    logic        clk;
    logic        rst_n;
    logic        blk_evt;
    logic [31:0] blk_addr;
    logic [15:0] blk_req_id;
    logic        blk_nonsec;
    logic        blk_lut_ns;
    logic        wr_set;
    logic        wr_clr;
    logic        wr_en;
    logic        wr_lsb;
    logic [2:0]  rd_sel;
    logic [31:0] rd_data;
    logic        irq;

    int n_chk  = 0;
    int n_fail = 0;

    blkcap_top dut_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .blk_evt    (blk_evt),
        .blk_addr   (blk_addr),
        .blk_req_id (blk_req_id),
        .blk_nonsec (blk_nonsec),
        .blk_lut_ns (blk_lut_ns),
        .wr_set     (wr_set),
        .wr_clr     (wr_clr),
        .wr_en      (wr_en),
        .wr_lsb     (wr_lsb),
        .rd_sel     (rd_sel),
        .rd_data    (rd_data),
        .irq        (irq)
    );

    // 50 MHz clock
    initial clk = 1'b0;
    always #10 clk = ~clk;

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
        end
    endtask

    task automatic rd(input logic [2:0] sel, output logic [31:0] val);
        rd_sel = sel;
        #1;
        val = rd_data;
    endtask

    // One clock of stimulus: inputs set at a falling edge, removed at the next.
    task automatic drive(input logic e, input logic [31:0] a, input logic [15:0] id,
                         input logic ns, input logic lut, input logic s,
                         input logic c, input logic en_w, input logic b);
        @(negedge clk);
        blk_evt = e; blk_addr = a; blk_req_id = id; blk_nonsec = ns; blk_lut_ns = lut;
        wr_set = s; wr_clr = c; wr_en = en_w; wr_lsb = b;
        @(negedge clk);
        blk_evt = 0; wr_set = 0; wr_clr = 0; wr_en = 0; wr_lsb = 0;
        blk_addr = '0; blk_req_id = '0; blk_nonsec = 0; blk_lut_ns = 0;
    endtask

    task automatic expect_state(input string req, input logic st, input logic en,
                                input logic [31:0] i1, input logic [31:0] i2);
        logic [31:0] v;
        rd(3'd0, v); check({req, " status"}, v, {31'b0, st});
        rd(3'd1, v); check({req, " enable"}, v, {31'b0, en});
        rd(3'd2, v); check({req, " info1"}, v, i1);
        rd(3'd3, v); check({req, " info2"}, v, i2);
        check({req, " irq"}, {31'b0, irq}, {31'b0, st & en});
    endtask

    task automatic t_reset();
        @(negedge clk); rst_n = 0;
        @(negedge clk); @(negedge clk); rst_n = 1;
        expect_state("R10 reset", 1'b0, 1'b1, 32'h0, 32'h0);
    endtask

    task automatic t_first_capture();
        drive(1, 32'hA000_1234, 16'h1234, 1, 0, 0, 0, 0, 0);
        expect_state("R2 R3 first capture", 1, 1, 32'hA000_1234, 32'h0001_1234);
    endtask

    task automatic t_hold();
        drive(1, 32'h5555_0000, 16'hBEEF, 0, 1, 0, 0, 0, 0);
        expect_state("R4 repeat event", 1, 1, 32'hA000_1234, 32'h0001_1234);
    endtask

    task automatic t_clear();
        drive(0, 0, 0, 0, 0, 0, 1, 0, 0);
        expect_state("R5 clear with 0", 1, 1, 32'hA000_1234, 32'h0001_1234);
        drive(0, 0, 0, 0, 0, 0, 1, 0, 1);
        expect_state("R5 clear with 1", 0, 1, 32'hA000_1234, 32'h0001_1234);
    endtask

    task automatic t_set();
        drive(0, 0, 0, 0, 0, 1, 0, 0, 0);
        expect_state("R6 set with 0", 0, 1, 32'hA000_1234, 32'h0001_1234);
        drive(0, 0, 0, 0, 0, 1, 0, 0, 1);
        expect_state("R6 set with 1", 1, 1, 32'hA000_1234, 32'h0001_1234);
    endtask

    task automatic t_set_clr_same();
        drive(0, 0, 0, 0, 0, 0, 1, 0, 1);
        drive(0, 0, 0, 0, 0, 1, 1, 0, 1);
        expect_state("R7 set and clear", 1, 1, 32'hA000_1234, 32'h0001_1234);
    endtask

    task automatic t_evt_clr_same();
        drive(1, 32'h0BAD_F00D, 16'hC0DE, 0, 1, 0, 1, 0, 1);
        expect_state("R8 event and clear", 1, 1, 32'h0BAD_F00D, 32'h0002_C0DE);
    endtask

    task automatic t_enable();
        drive(0, 0, 0, 0, 0, 0, 0, 1, 0);
        expect_state("R9 R1 enable off", 1, 0, 32'h0BAD_F00D, 32'h0002_C0DE);
        drive(0, 0, 0, 0, 0, 0, 1, 0, 1);
        drive(1, 32'h1357_9BDF, 16'hFFFF, 1, 1, 0, 0, 0, 0);
        expect_state("R2 R3 capture while disabled", 1, 0, 32'h1357_9BDF, 32'h0003_FFFF);
        drive(0, 0, 0, 0, 0, 0, 0, 1, 1);
        expect_state("R9 R1 enable on", 1, 1, 32'h1357_9BDF, 32'h0003_FFFF);
    endtask

    task automatic t_read_codes();
        logic [31:0] v;
        rd(3'd4, v); check("R11 set code reads zero", v, 32'h0);
        rd(3'd5, v); check("R11 clear code reads zero", v, 32'h0);
        rd(3'd7, v); check("R11 unused code reads zero", v, 32'h0);
    endtask

    // Watchdog: a hung run counts as a failure.
    initial begin
        #(20 * 200000);
        n_chk++; n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        rst_n = 0; blk_evt = 0; blk_addr = '0; blk_req_id = '0; blk_nonsec = 0;
        blk_lut_ns = 0; wr_set = 0; wr_clr = 0; wr_en = 0; wr_lsb = 0; rd_sel = '0;
        t_reset();
        t_first_capture();
        t_hold();
        t_clear();
        t_set();
        t_set_clr_same();
        t_evt_clr_same();
        t_enable();
        t_read_codes();
        t_reset();
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

endmodule